// File: doc/BRIEF.md
# Segmented Memory Address Translator

This block turns the logical addresses of a small processor core into physical memory targets. A 16-bit data address and an 18-bit instruction address are each translated in the same cycle into a target class, a physical offset, a unified-memory segment number and a fault flag. The result goes to the memory steering logic. Three map registers control the translation: one data map and two instruction maps. Software loads them through a single write port, and a write takes effect on the cycle after it is presented.

The data space has three regions. The low half goes straight to internal data RAM. The top quarter is an I/O range, of which only one 16-byte window is legal. The quarter between them is a 16 KiB window that the data map redirects. It points either into instruction RAM or into a page of a 128 KiB unified-memory segment. On the instruction side, the top address bit picks one of the two instruction maps. The chosen map sends the fetch either to instruction RAM unchanged or to a unified-memory segment. A per-segment presence vector lets the translator report fetches from segments that are not backed.

Top module: `seg_addr_xlat`

## Requirements
- R1: Target codes are 0 = data RAM, 1 = instruction RAM, 2 = unified memory, 3 = none. A data address below 0x8000 gives target 0, an offset equal to the address, segment 0 and no fault.
- R2: A data address of 0xC000 or above gives target 0, an offset equal to the address and segment 0. The fault flag is raised unless address bits [15:4] equal 0xFF0.
- R3: When bit 12 of the data map is set, a data address in 0x8000–0xBFFF gives target 1 with offset = map[3:0]·0x4000 + address[13:0], segment 0 and no fault.
- R4: When bit 12 of the data map is clear, a data address in 0x8000–0xBFFF gives target 2, segment = map[9:3] and offset = map[2:0]·0x4000 + address[13:0], with no fault.
- R5: Instruction address bit 17 selects instruction map B when set and instruction map A when clear.
- R6: When bit 12 of the selected instruction map is set, the instruction side gives target 1, an offset equal to the full 18-bit address, segment 0 and no fault.
- R7: When bit 12 of the selected instruction map is clear, the segment is map[7:0]. If that segment is present, the result is target 2 with offset = address[16:0] and no fault.
- R8: A unified-memory instruction segment counts as absent when its number is 128 or more, or when its bit in seg_valid is 0. An absent segment gives target 3, offset 0, the segment number on i_seg and the fault flag set.
- R9: While reset is asserted, and after it is released until the first write, the data map is 0x0000, instruction map A is 0x0000 and instruction map B is 0x007F.
- R10: A write with map_sel 0, 1 or 2 loads the data map, map A or map B. Translations change from the next cycle on, and the cycle of the write still uses the old value. A write with map_sel 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the map registers |
| map_we | input | 1 | Map register write strobe |
| map_sel | input | 2 | Map register select (0 data, 1 map A, 2 map B, 3 unused) |
| map_wdata | input | 16 | Map register write value |
| seg_valid | input | 128 | Per-segment presence bits for instruction fetches |
| d_addr | input | 16 | Data address |
| d_tgt | output | 2 | Data target code |
| d_off | output | 18 | Data physical offset |
| d_seg | output | 8 | Data unified segment number |
| d_fault | output | 1 | Data bus error |
| i_addr | input | 18 | Instruction address |
| i_tgt | output | 2 | Instruction target code |
| i_off | output | 18 | Instruction physical offset |
| i_seg | output | 8 | Instruction unified segment number |
| i_fault | output | 1 | Instruction bus error |

## Verification
The hardest cases to reach need a particular map value in place before the address arrives. Examples are an instruction fetch through map B into an absent segment numbered 128 or above, and a data window access with the page bits at their maximum. The stimulus writes chosen map values, changes seg_valid, and then sweeps addresses at the region edges (0x7FFF/0x8000, 0xBFFF/0xC000, 0xFEFF/0xFF00/0xFF0F/0xFF10) in the same and the following cycle. A long mixed phase interleaves random writes, including writes with the unused select code, with addresses drawn from every region. The reference model is compared with the outputs on every clock.

// File: rtl/seg_addr_xlat_pkg.sv
package seg_addr_xlat_pkg;
   typedef enum logic [1:0] {
      TGT_DRAM = 2'd0,
      TGT_IRAM = 2'd1,
      TGT_UMEM = 2'd2,
      TGT_NONE = 2'd3
   } xlat_tgt_e;

   typedef enum logic [1:0] {
      SEL_DMAP  = 2'd0,
      SEL_IMAPA = 2'd1,
      SEL_IMAPB = 2'd2,
      SEL_NONE  = 2'd3
   } map_sel_e;
endpackage

// File: rtl/sax_map_regs.sv
module sax_map_regs #(
   parameter int MAPW = 16,
   parameter logic [MAPW-1:0] RST_DMAP  = '0,
   parameter logic [MAPW-1:0] RST_IMAPA = '0,
   parameter logic [MAPW-1:0] RST_IMAPB = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [1:0]      sel,
   input  logic [MAPW-1:0] wdata,
   output logic [MAPW-1:0] dmap,
   output logic [MAPW-1:0] imap_a,
   output logic [MAPW-1:0] imap_b
);
   localparam int NREG = 3;

   logic [NREG-1:0][MAPW-1:0] q;

   for (genvar g = 0; g < NREG; g++) begin : g_map
      localparam logic [MAPW-1:0] RV = (g == 0) ? RST_DMAP :
                                       (g == 1) ? RST_IMAPA : RST_IMAPB;
      logic [MAPW-1:0] r;
      always_ff @(posedge clk) begin
         if (!rst_n)
            r <= RV;
         else if (we && (sel == 2'(g)))
            r <= wdata;
      end
      assign q[g] = r;
   end

   assign dmap   = q[0];
   assign imap_a = q[1];
   assign imap_b = q[2];
endmodule

// File: rtl/sax_data_xlat.sv
module sax_data_xlat
   import seg_addr_xlat_pkg::*;
#(
   parameter int MAPW    = 16,
   parameter int DAW     = 16,
   parameter int PAGEW   = 14,
   parameter int OFFW    = 18,
   parameter int SEGW    = 8,
   parameter int USEGW   = 17,
   parameter int DSEGW   = 7,
   parameter int SEL_BIT = 12,
   parameter logic [DAW-5:0] IO_WIN = '1
) (
   input  logic [MAPW-1:0] dmap,
   input  logic [DAW-1:0]  addr,
   output xlat_tgt_e       tgt,
   output logic [OFFW-1:0] off,
   output logic [SEGW-1:0] seg,
   output logic            fault
);
   localparam int IPGW = OFFW - PAGEW;
   localparam int UPGW = USEGW - PAGEW;

   logic [1:0]       region;
   logic [PAGEW-1:0] low;
   logic [IPGW-1:0]  ipage;
   logic [UPGW-1:0]  upage;
   logic [DSEGW-1:0] useg;

   assign region = addr[DAW-1 -: 2];
   assign low    = addr[PAGEW-1:0];
   assign ipage  = dmap[IPGW-1:0];
   assign upage  = dmap[UPGW-1:0];
   assign useg   = dmap[UPGW +: DSEGW];

   always_comb begin
      tgt   = TGT_DRAM;
      off   = OFFW'(addr);
      seg   = '0;
      fault = 1'b0;
      unique case (region)
         2'b00, 2'b01: ;
         2'b11: fault = (addr[DAW-1:4] != IO_WIN);
         default: begin
            if (dmap[SEL_BIT]) begin
               tgt = TGT_IRAM;
               off = {ipage, low};
            end else begin
               tgt = TGT_UMEM;
               off = OFFW'({upage, low});
               seg = SEGW'(useg);
            end
         end
      endcase
   end
endmodule

// File: rtl/sax_inst_xlat.sv
module sax_inst_xlat
   import seg_addr_xlat_pkg::*;
#(
   parameter int MAPW    = 16,
   parameter int IAW     = 18,
   parameter int USEGW   = 17,
   parameter int SEGW    = 8,
   parameter int NSEG    = 128,
   parameter int SEL_BIT = 12
) (
   input  logic [MAPW-1:0] imap_a,
   input  logic [MAPW-1:0] imap_b,
   input  logic [NSEG-1:0] seg_valid,
   input  logic [IAW-1:0]  addr,
   output xlat_tgt_e       tgt,
   output logic [IAW-1:0]  off,
   output logic [SEGW-1:0] seg,
   output logic            fault
);
   localparam int SIDXW = (NSEG > 1) ? $clog2(NSEG) : 1;

   logic [MAPW-1:0] map;
   logic [SEGW-1:0] s;
   logic            in_range;
   logic            present;

   assign map      = addr[IAW-1] ? imap_b : imap_a;
   assign s        = map[SEGW-1:0];
   assign in_range = ({1'b0, s} < (SEGW+1)'(NSEG));
   assign present  = in_range && seg_valid[s[SIDXW-1:0]];

   always_comb begin
      tgt   = TGT_IRAM;
      off   = addr;
      seg   = '0;
      fault = 1'b0;
      if (!map[SEL_BIT]) begin
         seg = s;
         if (present) begin
            tgt = TGT_UMEM;
            off = IAW'(addr[USEGW-1:0]);
         end else begin
            tgt   = TGT_NONE;
            off   = '0;
            fault = 1'b1;
         end
      end
   end
endmodule

// File: rtl/seg_addr_xlat.sv
module seg_addr_xlat
   import seg_addr_xlat_pkg::*;
#(
   parameter int MAPW    = 16,
   parameter int DAW     = 16,
   parameter int IAW     = 18,
   parameter int PAGEW   = 14,
   parameter int USEGW   = 17,
   parameter int DSEGW   = 7,
   parameter int SEGW    = 8,
   parameter int NSEG    = 128,
   parameter int SEL_BIT = 12,
   parameter logic [DAW-5:0]  IO_WIN    = 12'hFF0,
   parameter logic [MAPW-1:0] RST_DMAP  = 16'h0000,
   parameter logic [MAPW-1:0] RST_IMAPA = 16'h0000,
   parameter logic [MAPW-1:0] RST_IMAPB = 16'h007F
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            map_we,
   input  logic [1:0]      map_sel,
   input  logic [MAPW-1:0] map_wdata,
   input  logic [NSEG-1:0] seg_valid,
   input  logic [DAW-1:0]  d_addr,
   output logic [1:0]      d_tgt,
   output logic [IAW-1:0]  d_off,
   output logic [SEGW-1:0] d_seg,
   output logic            d_fault,
   input  logic [IAW-1:0]  i_addr,
   output logic [1:0]      i_tgt,
   output logic [IAW-1:0]  i_off,
   output logic [SEGW-1:0] i_seg,
   output logic            i_fault
);
   localparam int OFFW = IAW;

   if (DAW != PAGEW + 2) begin : g_bad_daw
      $error("data address must be two bits wider than a page");
   end
   if (IAW <= USEGW || USEGW <= PAGEW) begin : g_bad_widths
      $error("instruction address must exceed segment width, segment must exceed page");
   end
   if (NSEG > (1 << SEGW) || SEL_BIT >= MAPW || DSEGW + USEGW - PAGEW > MAPW) begin : g_bad_map
      $error("map or segment parameters out of range");
   end

   logic [MAPW-1:0] dmap, imap_a, imap_b;
   xlat_tgt_e       d_tgt_e, i_tgt_e;

   sax_map_regs #(
      .MAPW(MAPW), .RST_DMAP(RST_DMAP), .RST_IMAPA(RST_IMAPA), .RST_IMAPB(RST_IMAPB)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(map_we), .sel(map_sel), .wdata(map_wdata),
      .dmap(dmap), .imap_a(imap_a), .imap_b(imap_b)
   );

   sax_data_xlat #(
      .MAPW(MAPW), .DAW(DAW), .PAGEW(PAGEW), .OFFW(OFFW), .SEGW(SEGW),
      .USEGW(USEGW), .DSEGW(DSEGW), .SEL_BIT(SEL_BIT), .IO_WIN(IO_WIN)
   ) u_data (
      .dmap(dmap), .addr(d_addr), .tgt(d_tgt_e), .off(d_off), .seg(d_seg), .fault(d_fault)
   );

   sax_inst_xlat #(
      .MAPW(MAPW), .IAW(IAW), .USEGW(USEGW), .SEGW(SEGW), .NSEG(NSEG), .SEL_BIT(SEL_BIT)
   ) u_inst (
      .imap_a(imap_a), .imap_b(imap_b), .seg_valid(seg_valid), .addr(i_addr),
      .tgt(i_tgt_e), .off(i_off), .seg(i_seg), .fault(i_fault)
   );

   assign d_tgt = d_tgt_e;
   assign i_tgt = i_tgt_e;

   // R1
   dlow_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !d_addr[DAW-1] |-> (d_tgt == TGT_DRAM && d_off == OFFW'(d_addr) && !d_fault));

   // R2
   dfault_io_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      d_fault |-> (d_addr[DAW-1 -: 2] == 2'b11 && d_tgt == TGT_DRAM));

   // R4
   dseg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (d_tgt != TGT_UMEM) |-> (d_seg == '0));

   // R8
   ifault_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      i_fault |-> (i_tgt == TGT_NONE && i_off == '0));

   // R10
   map_b_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (map_we && map_sel == SEL_IMAPB && map_wdata[SEL_BIT]) |=>
         (!i_addr[IAW-1] || i_tgt == TGT_IRAM));
endmodule

// File: tb/seg_addr_xlat_bench.sv
module seg_addr_xlat_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         map_we = 1'b0;
   logic [1:0]   map_sel = 2'd0;
   logic [15:0]  map_wdata = 16'd0;
   logic [127:0] seg_valid = '1;
   logic [15:0]  d_addr = 16'd0;
   logic [17:0]  i_addr = 18'd0;
   logic [1:0]   d_tgt, i_tgt;
   logic [17:0]  d_off, i_off;
   logic [7:0]   d_seg, i_seg;
   logic         d_fault, i_fault;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int m_d, m_a, m_b;

   always #2 clk = ~clk;

   seg_addr_xlat u_seg_addr_xlat (
      .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_sel(map_sel), .map_wdata(map_wdata),
      .seg_valid(seg_valid), .d_addr(d_addr), .d_tgt(d_tgt), .d_off(d_off), .d_seg(d_seg),
      .d_fault(d_fault), .i_addr(i_addr), .i_tgt(i_tgt), .i_off(i_off), .i_seg(i_seg),
      .i_fault(i_fault)
   );

   task automatic compare(string tag, int at, int ao, int as, int af,
                          int et, int eo, int es, int ef);
      checks++;
      if (at != et || ao != eo || as != es || af != ef) begin
         fails++;
         $display("FAIL %s: actual tgt=%0d off=%h seg=%0d fault=%0d expected tgt=%0d off=%h seg=%0d fault=%0d",
                  tag, at, ao, as, af, et, eo, es, ef);
      end
   endtask

   task automatic check_now();
      int a, t, o, s, f, m;
      string tag;
      a = d_addr; s = 0; f = 0; o = a; t = 0;
      if (a < 'h8000) tag = "R1 data low";
      else if (a >= 'hC000) begin
         tag = "R2 data io";
         f = ((a >> 4) != 'hFF0) ? 1 : 0;
      end else if ((m_d >> 12) & 1) begin
         tag = "R3 data window iram";
         t = 1; o = (m_d & 15) * 16384 + (a - 'h8000);
      end else begin
         tag = "R4 data window umem";
         t = 2; s = (m_d >> 3) & 127; o = (m_d & 7) * 16384 + (a - 'h8000);
      end
      if (!rst_n) tag = {tag, " R9"};
      compare(tag, d_tgt, d_off, d_seg, d_fault, t, o, s, f);

      a = i_addr;
      m = (a >= 'h20000) ? m_b : m_a;
      tag = (a >= 'h20000) ? "R5 map B" : "R5 map A";
      if ((m >> 12) & 1) begin
         tag = {tag, " R6"}; t = 1; o = a; s = 0; f = 0;
      end else begin
         s = m & 255;
         if (s >= 128 || !seg_valid[s[6:0]]) begin
            tag = {tag, " R8"}; t = 3; o = 0; f = 1;
         end else begin
            tag = {tag, " R7"}; t = 2; o = a & 'h1FFFF; f = 0;
         end
      end
      if (!rst_n) tag = {tag, " R9"};
      compare(tag, i_tgt, i_off, i_seg, i_fault, t, o, s, f);
   endtask

   // One clock: drive, compare mid-cycle, then model the edge (R10).
   task automatic cyc(bit we, int sel, int wd, int da, int ia);
      map_we = we; map_sel = 2'(sel); map_wdata = 16'(wd);
      d_addr = 16'(da); i_addr = 18'(ia);
      #1;
      check_now();
      @(posedge clk);
      if (!rst_n) begin
         m_d = 0; m_a = 0; m_b = 'h7F;
      end else if (we) begin
         if (sel == 0) m_d = wd & 'hFFFF;
         else if (sel == 1) m_a = wd & 'hFFFF;
         else if (sel == 2) m_b = wd & 'hFFFF;
      end
      @(negedge clk);
   endtask

   task automatic sweep(int m);
      int edges[10] = '{'h0000, 'h7FFF, 'h8000, 'h9234, 'hBFFF, 'hC000,
                        'hFEFF, 'hFF00, 'hFF0F, 'hFF10};
      foreach (edges[k]) cyc(0, 0, 0, edges[k], (k * 'h5A5B) ^ ((k & 1) << 17));
      cyc(1, 0, m, 'h8001, 'h20000);
      cyc(0, 0, 0, 'hA5A5, 'h3FFFF);
   endtask

   initial begin
      m_d = 0; m_a = 0; m_b = 'h7F;
      @(negedge clk);
      // R9: reset state, including writes that must not land
      cyc(1, 0, 'h1FFF, 'h8123, 'h00010);
      cyc(1, 2, 'h1000, 'hBFFF, 'h20010);
      cyc(0, 0, 0, 'h8000, 'h3FFFF);
      rst_n = 1'b1;
      @(negedge clk);
      cyc(0, 0, 0, 'h8000, 'h3FFFF);
      cyc(0, 0, 0, 'hFF05, 'h1ABCD);
      // R3, R4 window through several data map values
      sweep('h100F);
      sweep('h03FF);
      sweep('h03F8);
      sweep('h1000);
      sweep('h0007);
      // R10: unused select code leaves every map alone
      cyc(1, 3, 'h1FFF, 'h8000, 'h20000);
      cyc(0, 0, 0, 'h8000, 'h20000);
      cyc(0, 0, 0, 'h8000, 'h00000);
      // R5..R8: instruction maps and segment presence
      cyc(1, 1, 'h1000, 'h0, 'h1FFFF);
      cyc(0, 0, 0, 'h0, 'h1FFFF);
      cyc(1, 2, 'h0080, 'h0, 'h20001);
      cyc(0, 0, 0, 'h0, 'h20001);
      cyc(1, 2, 'h00FF, 'h0, 'h3FFFF);
      cyc(0, 0, 0, 'h0, 'h3FFFF);
      cyc(1, 1, 'h0005, 'h0, 'h00123);
      seg_valid[5] = 1'b0;
      cyc(0, 0, 0, 'h0, 'h00123);
      seg_valid[5] = 1'b1;
      cyc(0, 0, 0, 'h0, 'h00123);
      cyc(1, 2, 'h007F, 'h0, 'h3ABCD);
      seg_valid[127] = 1'b0;
      cyc(0, 0, 0, 'h0, 'h3ABCD);
      seg_valid = '1;
      // mixed phase
      for (int n = 0; n < 4000; n++) begin
         int da, ia, wd;
         bit we;
         da = $urandom_range(0, 3);
         case (da)
            0: da = $urandom_range(0, 'h7FFF);
            1: da = $urandom_range('h8000, 'hBFFF);
            2: da = 'hFF00 + $urandom_range(0, 31);
            default: da = $urandom_range('hC000, 'hFFFF);
         endcase
         ia = $urandom_range(0, 'h3FFFF);
         wd = $urandom_range(0, 'hFFFF);
         if ($urandom_range(0, 1)) wd = (wd & 'hEFFF) | ($urandom_range(0, 3) == 0 ? 'h1000 : 0);
         we = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 7) == 0) seg_valid[$urandom_range(0, 127)] ^= 1'b1;
         cyc(we, $urandom_range(0, 3), wd, da, ia);
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule